// File: doc/BRIEF.md
# DMA Peripheral Handshake Unit

This block sits between one DMA channel engine and the device that channel serves. It turns a device's request line into per-beat transfer grants. The request line can be sensed as a level or as an edge, in either polarity. The block drives an acknowledge pin whose active level is programmable. It also handles a single shared end-of-transfer / terminal-count pin. That pin is either an input, on which the device can cut a buffer short, or an output, which pulses on the last beat of a buffer. In either direction the pin can be active-low or active-high.

The channel engine loads one buffer at a time. It pulses `buf_start` together with the slot number (0 or 1) and the beat count. The block then grants beats until the count is used up or the device signals end-of-transfer, and pulses `buf_end` when the buffer is finished. In no-handshake mode the request line is ignored and beats are paced by a programmed wait-state count. A request can come from the external pin or from one of three internal requesters. All configuration comes from a 32-bit control word, whose bit positions are fixed because the channel's register block decodes the same word. The control word must stay stable while a buffer is active.

The controller has four states. ST_IDLE means no buffer is loaded. ST_WAIT_REQ waits for a qualified request. ST_PACE counts wait states. ST_BEAT is the single grant cycle. The transitions are:
- load: ST_IDLE to ST_WAIT_REQ, or to ST_PACE in no-handshake mode.
- request seen: ST_WAIT_REQ to ST_BEAT.
- pace expiry: ST_PACE to ST_BEAT.
- next beat: ST_BEAT back to ST_WAIT_REQ or ST_PACE.
- terminal count: ST_BEAT to ST_IDLE on the last beat.
- early end: ST_WAIT_REQ or ST_PACE to ST_IDLE when end-of-transfer is sensed.

Top module: `hs_dma_handshake`

## Requirements
- R1: The request mode is set by `ctrl_word[20:19]`: 0 = active-low level, 1 = active-high level, 2 = active-low edge, 3 = active-high edge. The external request passes through a two-flop synchronizer. In a level mode, a buffer in ST_WAIT_REQ is granted one beat (`grant` high for one cycle) in the cycle after the synchronized level is active.
- R2: In an edge mode, each synchronized edge of the selected polarity is latched as a pending request. The pending request is cleared by the acknowledge, so every edge yields exactly one beat.
- R3: `ctrl_word[17]` sets the acknowledge polarity (1 = active-high). In handshake mode `ack_pin` is at its active level exactly in grant cycles. In no-handshake mode, and outside grant cycles, it is at its inactive level.
- R4: `ctrl_word[16:15]` sets the pin mode: 0 = active-low end-of-transfer input, 1 = active-high end-of-transfer input, 2 = active-low terminal-count output, 3 = active-high terminal-count output. `tc_pin_oe` is high for codes 2 and 3. `tc_pin_out` is at its active level for one cycle, coinciding with the last beat of a buffer.
- R5: In an input pin mode, a synchronized active end-of-transfer level sensed in ST_WAIT_REQ or ST_PACE ends the buffer early. It pulses `buf_end` and sets `eot_flags[slot]`.
- R6: `ctrl_word[24]` selects no-handshake mode. In this mode each beat is preceded by N+1 pacing cycles, where N = `ctrl_word[31:25]`, and the request inputs are ignored.
- R7: `ctrl_word[10:9]` sets the peripheral width, and `beat_bytes` reports it during a grant: 0 gives 1, 1 gives 2, 2 gives 4. Otherwise `beat_bytes` is 0. Code 3 is unused: a buffer load with it is ignored.
- R8: `ctrl_word[23:22]` selects the request source: 0 = external pin, 1/2/3 = `int_req_in[0]`/`[1]`/`[2]`. An internal source is an active-high, same-clock level that bypasses polarity, edge sensing and synchronization.
- R9: `req_live` shows the current conditioned request level of the selected source: the synchronized external level after the polarity bit `ctrl_word[19]`, or the selected internal line.
- R10: `tc_flags[slot]` is set when a buffer in that slot reaches its terminal count. Both flags can be set at once. Loading a new buffer into a slot clears that slot's `tc_flags` and `eot_flags` bits.
- R11: After reset the unit is in ST_IDLE: `grant` and `buf_end` low, both flag pairs zero, and `ack_pin` at its inactive level.
- R12: `buf_start` is ignored while a buffer is active and when `buf_beats` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Channel control word (fields as in the requirements) |
| buf_start | input | 1 | Load-buffer pulse from the channel engine |
| buf_slot | input | 1 | Buffer slot of the load |
| buf_beats | input | BEAT_W | Beats in the loaded buffer |
| req_pin | input | 1 | External device request (asynchronous) |
| int_req_in | input | 3 | Internal requesters for source codes 1..3 |
| eot_pin_in | input | 1 | Input side of the end-of-transfer / terminal-count pin |
| grant | output | 1 | One-cycle beat grant to the channel engine |
| beat_bytes | output | 3 | Bytes of the granted beat |
| ack_pin | output | 1 | Device acknowledge |
| tc_pin_out | output | 1 | Output side of the shared pin |
| tc_pin_oe | output | 1 | Output enable of the shared pin |
| buf_end | output | 1 | Buffer finished (terminal count or early end) |
| req_live | output | 1 | Conditioned live request level |
| tc_flags | output | 2 | Terminal-count status per slot |
| eot_flags | output | 2 | End-of-transfer status per slot |

## Verification
The bench builds the unit with its defaults: BEAT_W = 16 and a two-flop synchronizer. Buffers of up to fifty beats and the full two-cycle synchronizer latency are therefore exercised on every request and end-of-transfer path. A wait-state count of 3 makes pacing gaps long enough to see that no-handshake beats ignore the request line. Running both slots back to back brings the both-flags-set status and the clear-on-reload behaviour within reach.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int WIDTH_LSB    = 9;
    localparam int PIN_MODE_LSB = 15;
    localparam int ACK_POL_BIT  = 17;
    localparam int RQ_MODE_LSB  = 19;
    localparam int SRC_LSB      = 22;
    localparam int NOHS_BIT     = 24;
    localparam int WAIT_LSB     = 25;
    localparam int WAIT_W       = 32 - WAIT_LSB;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_REQ = 2'd1,
        ST_PACE     = 2'd2,
        ST_BEAT     = 2'd3
    } hs_state_e;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES < 2) begin : g_single
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hs_req_cond.sv
module hs_req_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_pin,
    input  logic [2:0] int_req_in,
    input  logic [1:0] mode,
    input  logic [1:0] src,
    input  logic       ack_clr,
    output logic       req_ok,
    output logic       req_live
);
    logic sync_lvl, prev_q, pend_q, edge_hit, lvl, int_sel;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(req_pin), .q(sync_lvl)
    );

    assign lvl      = mode[0] ? sync_lvl : ~sync_lvl;
    assign edge_hit = mode[0] ? (sync_lvl & ~prev_q) : (~sync_lvl & prev_q);
    assign int_sel  = (src == 2'd0) ? 1'b0 : int_req_in[src - 2'd1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= sync_lvl;
            if (mode[1] && edge_hit) pend_q <= 1'b1;
            else if (ack_clr)        pend_q <= 1'b0;
        end
    end

    assign req_ok   = (src == 2'd0) ? (mode[1] ? pend_q : lvl) : int_sel;
    assign req_live = (src == 2'd0) ? lvl : int_sel;
endmodule

// File: rtl/hs_pace_cnt.sv
module hs_pace_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (dec && cnt_q != '0)   cnt_q <= cnt_q - {{(W-1){1'b0}}, 1'b1};
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/hs_eot_pin.sv
module hs_eot_pin #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eot_pin_in,
    input  logic [1:0] pin_mode,
    input  logic       tc_fire,
    output logic       eot_act,
    output logic       tc_out,
    output logic       tc_oe
);
    logic sync_lvl;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(eot_pin_in), .q(sync_lvl)
    );

    assign eot_act = ~pin_mode[1] & (pin_mode[0] ? sync_lvl : ~sync_lvl);
    assign tc_oe   = pin_mode[1];
    assign tc_out  = pin_mode[1] ? (tc_fire ? pin_mode[0] : ~pin_mode[0]) : 1'b0;
endmodule

// File: rtl/hs_dma_handshake.sv
module hs_dma_handshake
    import hs_pkg::*;
#(
    parameter int BEAT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl_word,
    input  logic              buf_start,
    input  logic              buf_slot,
    input  logic [BEAT_W-1:0] buf_beats,
    input  logic              req_pin,
    input  logic [2:0]        int_req_in,
    input  logic              eot_pin_in,
    output logic              grant,
    output logic [2:0]        beat_bytes,
    output logic              ack_pin,
    output logic              tc_pin_out,
    output logic              tc_pin_oe,
    output logic              buf_end,
    output logic              req_live,
    output logic [1:0]        tc_flags,
    output logic [1:0]        eot_flags
);
    localparam logic [BEAT_W-1:0] ONE_BEAT = BEAT_W'(1);

    logic [1:0]        rq_mode, pin_mode, width, src;
    logic              ack_pol, no_hs;
    logic [WAIT_W-1:0] wait_n;

    assign width    = ctrl_word[WIDTH_LSB +: 2];
    assign pin_mode = ctrl_word[PIN_MODE_LSB +: 2];
    assign ack_pol  = ctrl_word[ACK_POL_BIT];
    assign rq_mode  = ctrl_word[RQ_MODE_LSB +: 2];
    assign src      = ctrl_word[SRC_LSB +: 2];
    assign no_hs    = ctrl_word[NOHS_BIT];
    assign wait_n   = ctrl_word[WAIT_LSB +: WAIT_W];

    hs_state_e         state_q, state_d;
    logic [BEAT_W-1:0] rem_q;
    logic              slot_q;
    logic [1:0]        tc_q, eot_q;
    logic              req_ok, eot_act, pace_zero, pace_load, pace_dec;
    logic              start_ok, last_beat, ack_clr, tc_fire, early_end;

    assign start_ok  = buf_start && (width != 2'b11) && (buf_beats != '0);
    assign last_beat = (rem_q == ONE_BEAT);
    assign ack_clr   = (state_q == ST_BEAT) && !no_hs;
    assign tc_fire   = (state_q == ST_BEAT) && last_beat;
    assign early_end = ((state_q == ST_WAIT_REQ) || (state_q == ST_PACE)) && eot_act;
    assign pace_load = no_hs && (((state_q == ST_IDLE) && start_ok) ||
                                 ((state_q == ST_BEAT) && !last_beat));
    assign pace_dec  = (state_q == ST_PACE);

    hs_req_cond #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .int_req_in(int_req_in),
        .mode(rq_mode), .src(src), .ack_clr(ack_clr),
        .req_ok(req_ok), .req_live(req_live)
    );

    hs_pace_cnt #(.W(WAIT_W)) u_pace (
        .clk(clk), .rst_n(rst_n), .load(pace_load), .load_val(wait_n),
        .dec(pace_dec), .zero(pace_zero)
    );

    hs_eot_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk(clk), .rst_n(rst_n), .eot_pin_in(eot_pin_in), .pin_mode(pin_mode),
        .tc_fire(tc_fire), .eot_act(eot_act), .tc_out(tc_pin_out), .tc_oe(tc_pin_oe)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_ok) state_d = no_hs ? ST_PACE : ST_WAIT_REQ;
            ST_WAIT_REQ: if (eot_act) state_d = ST_IDLE;
                         else if (req_ok) state_d = ST_BEAT;
            ST_PACE:     if (eot_act) state_d = ST_IDLE;
                         else if (pace_zero) state_d = ST_BEAT;
            ST_BEAT:     if (last_beat) state_d = ST_IDLE;
                         else state_d = no_hs ? ST_PACE : ST_WAIT_REQ;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Buffer bookkeeping and per-slot status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            slot_q <= 1'b0;
            tc_q   <= '0;
            eot_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && start_ok) begin
                rem_q           <= buf_beats;
                slot_q          <= buf_slot;
                tc_q[buf_slot]  <= 1'b0;
                eot_q[buf_slot] <= 1'b0;
            end
            if (state_q == ST_BEAT) rem_q <= rem_q - ONE_BEAT;
            if (tc_fire)            tc_q[slot_q]  <= 1'b1;
            if (early_end)          eot_q[slot_q] <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        grant      = (state_q == ST_BEAT);
        beat_bytes = grant ? width_bytes(width) : 3'd0;
        ack_pin    = (grant && !no_hs) ? ack_pol : ~ack_pol;
        buf_end    = tc_fire || early_end;
        tc_flags   = tc_q;
        eot_flags  = eot_q;
    end
endmodule

// File: rtl/hs_dma_handshake_chk.sv
module hs_dma_handshake_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_word,
    input logic        grant,
    input logic [2:0]  beat_bytes,
    input logic        ack_pin,
    input logic        tc_pin_out,
    input logic        tc_pin_oe,
    input logic        buf_end
);
    AST_ACK_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !ctrl_word[24]) |-> (ack_pin == ctrl_word[17])); // R3
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (ack_pin != ctrl_word[17])); // R3
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pin_oe && tc_pin_out == ctrl_word[15]) |=> (tc_pin_out != ctrl_word[15])); // R4
    AST_TC_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pin_oe && tc_pin_out == ctrl_word[15]) |-> (grant && buf_end)); // R4
    AST_NO_WIDTH3_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (ctrl_word[10:9] != 2'b11 && $onehot(beat_bytes))); // R7
endmodule

bind hs_dma_handshake hs_dma_handshake_chk u_chk (.*);

// File: tb/hs_dma_handshake_tb.sv
`timescale 1ns/1ps
module hs_dma_handshake_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl = 32'd0;
    logic        buf_start = 1'b0, buf_slot = 1'b0;
    logic [15:0] buf_beats = 16'd0;
    logic        req_pin = 1'b1;
    logic [2:0]  int_req_in = 3'b000;
    logic        eot_pin_in = 1'b1;
    logic        grant, ack_pin, tc_pin_out, tc_pin_oe, buf_end, req_live;
    logic [2:0]  beat_bytes;
    logic [1:0]  tc_flags, eot_flags;

    int checks = 0, fails = 0, gcnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hs_dma_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .buf_start(buf_start),
        .buf_slot(buf_slot), .buf_beats(buf_beats), .req_pin(req_pin),
        .int_req_in(int_req_in), .eot_pin_in(eot_pin_in), .grant(grant),
        .beat_bytes(beat_bytes), .ack_pin(ack_pin), .tc_pin_out(tc_pin_out),
        .tc_pin_oe(tc_pin_oe), .buf_end(buf_end), .req_live(req_live),
        .tc_flags(tc_flags), .eot_flags(eot_flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int rmode, input int apol, input int pmode,
                                        input int wid, input int nohs, input int waitn,
                                        input int src);
        logic [31:0] w = 32'd0;
        w[20:19] = rmode[1:0]; w[17] = apol[0]; w[16:15] = pmode[1:0];
        w[10:9] = wid[1:0]; w[24] = nohs[0]; w[31:25] = waitn[6:0]; w[23:22] = src[1:0];
        return w;
    endfunction

    // Behavioural reference model
    int m_s1, m_s2, m_prev, m_e1, m_e2, m_pend, m_st, m_rem, m_cnt, m_slot;
    int m_tc[2], m_eot[2];

    function automatic int req_level();
        int src = ctrl[23:22];
        if (src == 0) return ctrl[19] ? m_s2 : !m_s2;
        return int_req_in[src-1];
    endfunction

    function automatic int eot_level();
        if (ctrl[16]) return 0;
        return ctrl[15] ? m_e2 : !m_e2;
    endfunction

    always @(posedge clk) begin : model
        int n_st, n_rem, n_cnt, n_pend, ok, edg, nh, st_ok;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_e1 = 0; m_e2 = 0; m_pend = 0;
            m_st = 0; m_rem = 0; m_cnt = 0; m_slot = 0;
            m_tc[0] = 0; m_tc[1] = 0; m_eot[0] = 0; m_eot[1] = 0;
        end else begin
            nh = ctrl[24];
            edg = ctrl[19] ? (m_s2 && !m_prev) : (!m_s2 && m_prev);
            if (ctrl[23:22] == 0) ok = ctrl[20] ? m_pend : req_level();
            else ok = req_level();
            st_ok = buf_start && ctrl[10:9] != 3 && buf_beats != 0;
            n_st = m_st; n_rem = m_rem; n_cnt = m_cnt; n_pend = m_pend;
            if (ctrl[20] && edg) n_pend = 1;
            else if (m_st == 3 && !nh) n_pend = 0;
            if (m_st == 2 && m_cnt != 0) n_cnt = m_cnt - 1;
            case (m_st)
                0: if (st_ok) begin
                       n_st = nh ? 2 : 1; n_rem = buf_beats; m_slot = buf_slot;
                       m_tc[buf_slot] = 0; m_eot[buf_slot] = 0;
                       if (nh) n_cnt = ctrl[31:25];
                   end
                1: if (eot_level()) begin n_st = 0; m_eot[m_slot] = 1; end
                   else if (ok) n_st = 3;
                2: if (eot_level()) begin n_st = 0; m_eot[m_slot] = 1; end
                   else if (m_cnt == 0) n_st = 3;
                default: begin
                    n_rem = m_rem - 1;
                    if (m_rem == 1) begin n_st = 0; m_tc[m_slot] = 1; end
                    else begin
                        n_st = nh ? 2 : 1;
                        if (nh) n_cnt = ctrl[31:25];
                    end
                end
            endcase
            m_st = n_st; m_rem = n_rem; m_cnt = n_cnt; m_pend = n_pend;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = req_pin;
            m_e2 = m_e1; m_e1 = eot_pin_in;
        end
    end

    always @(negedge clk) begin : compare
        int eg, ea, eb, efire, eto, eend;
        if (!done) begin
            eg = (m_st == 3);
            ea = (eg && !ctrl[24]) ? ctrl[17] : !ctrl[17];
            eb = !eg ? 0 : (ctrl[10:9] == 0 ? 1 : ctrl[10:9] == 1 ? 2 : ctrl[10:9] == 2 ? 4 : 0);
            efire = eg && m_rem == 1;
            eto = ctrl[16] ? (efire ? ctrl[15] : !ctrl[15]) : 0;
            eend = efire || ((m_st == 1 || m_st == 2) && eot_level());
            chk(grant == eg, "R1 grant", grant, eg);
            chk(ack_pin == ea, "R3 ack_pin", ack_pin, ea);
            chk(beat_bytes == eb, "R7 beat_bytes", beat_bytes, eb);
            chk(tc_pin_oe == ctrl[16] && tc_pin_out == eto, "R4 tc pin", tc_pin_out, eto);
            chk(buf_end == eend, "R5 buf_end", buf_end, eend);
            chk(req_live == req_level(), "R9 req_live", req_live, req_level());
            chk(tc_flags == {m_tc[1][0], m_tc[0][0]}, "R10 tc_flags", tc_flags, m_tc[1]*2 + m_tc[0]);
            chk(eot_flags == {m_eot[1][0], m_eot[0][0]}, "R5 eot_flags", eot_flags, m_eot[1]*2 + m_eot[0]);
            if (grant) gcnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic load(input bit slot, input int beats);
        buf_start = 1'b1; buf_slot = slot; buf_beats = beats[15:0];
        cyc(1);
        buf_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        cyc(3);
        @(negedge clk);
        chk(grant == 0 && buf_end == 0, "R11 reset grant", grant, 0);
        chk(tc_flags == 0 && eot_flags == 0, "R11 reset flags", tc_flags, 0);
        chk(ack_pin == 1, "R11 reset ack inactive", ack_pin, 1);
        rst_n = 1'b1;
        cyc(4);

        // Level active-high, word width, active-high tc output
        ctrl = mk(1, 1, 3, 2, 0, 0, 0); req_pin = 1'b0; cyc(4);
        req_pin = 1'b1; gcnt = 0; load(0, 3); cyc(20);
        chk(gcnt == 3, "R1 level-high beats", gcnt, 3);
        chk(tc_flags == 2'b01, "R10 slot0 tc", tc_flags, 1);

        // Level active-low, halfword, active-low tc, active-low ack
        req_pin = 1'b1; cyc(4);
        ctrl = mk(0, 0, 2, 1, 0, 0, 0); cyc(4);
        gcnt = 0; load(1, 2); req_pin = 1'b0; cyc(20);
        chk(gcnt == 2, "R1 level-low beats", gcnt, 2);
        chk(tc_flags == 2'b11, "R10 both slots tc", tc_flags, 3);
        req_pin = 1'b1; cyc(4);

        // Edge active-high
        req_pin = 1'b0; cyc(4);
        ctrl = mk(3, 1, 3, 0, 0, 0, 0); cyc(4);
        gcnt = 0; load(0, 3); cyc(1);
        chk(tc_flags == 2'b10, "R10 reload clears slot0", tc_flags, 2);
        cyc(8);
        chk(gcnt == 0, "R2 no edge no beat", gcnt, 0);
        req_pin = 1'b1; cyc(1); req_pin = 1'b0; cyc(8);
        chk(gcnt == 1, "R2 one edge one beat", gcnt, 1);
        for (int i = 0; i < 2; i++) begin
            req_pin = 1'b1; cyc(1); req_pin = 1'b0; cyc(8);
        end
        chk(gcnt == 3, "R2 edge-high beats", gcnt, 3);

        // Edge active-low
        ctrl = mk(2, 1, 3, 1, 0, 0, 0); cyc(4);
        req_pin = 1'b1; cyc(6);
        gcnt = 0; load(1, 2); cyc(6);
        for (int i = 0; i < 2; i++) begin
            req_pin = 1'b0; cyc(1); req_pin = 1'b1; cyc(8);
        end
        chk(gcnt == 2, "R2 edge-low beats", gcnt, 2);

        // No-handshake pacing, request line held inactive
        ctrl = mk(1, 1, 3, 0, 1, 3, 0); req_pin = 1'b0; cyc(4);
        gcnt = 0; load(0, 4); cyc(3);
        chk(gcnt == 0, "R6 pacing before first beat", gcnt, 0);
        cyc(27);
        chk(gcnt == 4, "R6 paced beats", gcnt, 4);

        // Early end, active-high input, no request
        ctrl = mk(1, 1, 1, 2, 0, 0, 0); eot_pin_in = 1'b0; cyc(4);
        gcnt = 0; load(0, 10); cyc(5);
        eot_pin_in = 1'b1; cyc(1); eot_pin_in = 1'b0; cyc(6);
        chk(eot_flags == 2'b01, "R5 eot slot0", eot_flags, 1);
        chk(gcnt == 0, "R5 no beats before eot", gcnt, 0);

        // Early end, active-low input, request streaming
        eot_pin_in = 1'b1; ctrl = mk(1, 1, 0, 2, 0, 0, 0); cyc(4);
        gcnt = 0; req_pin = 1'b1; load(1, 50); cyc(8);
        eot_pin_in = 1'b0; cyc(3); eot_pin_in = 1'b1; cyc(6);
        chk(eot_flags == 2'b11, "R5 eot both slots", eot_flags, 3);
        chk(gcnt > 0 && gcnt < 50, "R5 early end cut beats", gcnt, 1);
        req_pin = 1'b0; cyc(4);

        // Internal requesters
        ctrl = mk(1, 1, 3, 2, 0, 0, 2); int_req_in = 3'b010; cyc(2);
        gcnt = 0; load(0, 3); cyc(12);
        chk(gcnt == 3, "R8 internal source 2", gcnt, 3);
        int_req_in = 3'b000; req_pin = 1'b1;
        ctrl = mk(1, 1, 3, 2, 0, 0, 3); cyc(4);
        gcnt = 0; load(1, 1); cyc(10);
        chk(gcnt == 0, "R8 external pin ignored", gcnt, 0);
        int_req_in = 3'b100; cyc(6);
        chk(gcnt == 1, "R8 internal source 3", gcnt, 1);
        int_req_in = 3'b000; req_pin = 1'b0; cyc(4);

        // Unused width code
        ctrl = mk(1, 1, 3, 3, 0, 0, 0); req_pin = 1'b1; cyc(4);
        gcnt = 0; load(0, 2); cyc(10);
        chk(gcnt == 0, "R7 width code 3 ignored", gcnt, 0);
        chk(tc_flags == 2'b11, "R7 flags untouched", tc_flags, 3);

        // Ignored loads: zero beats and while busy
        ctrl = mk(1, 1, 3, 2, 0, 0, 0); req_pin = 1'b0; cyc(4);
        gcnt = 0; load(0, 0); cyc(6);
        chk(tc_flags == 2'b11, "R12 zero-beat load ignored", tc_flags, 3);
        load(0, 2); cyc(2); load(1, 5); cyc(2);
        chk(tc_flags == 2'b10, "R12 busy load ignored", tc_flags, 2);
        req_pin = 1'b1; cyc(20);
        chk(gcnt == 2, "R12 only first buffer ran", gcnt, 2);
        chk(tc_flags == 2'b11, "R10 slot0 tc again", tc_flags, 3);
        req_pin = 1'b0; cyc(4);

        finish_run();
    end
endmodule